// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Outputs

This block is a four-bit synchronous reversible counter. Every state bit changes on the same rising clock edge, so the count output has no intermediate codes between two values. An elaboration parameter selects one of two counting ranges: plain binary, which wraps between 15 and 0, or decade BCD, which runs 0 to 9 and wraps between 9 and 0. Counting needs an active-low enable. A direction input selects increment or decrement. An active-low preset input loads a data word into the count at once, without waiting for a clock edge, and it overrides counting.

Two outputs support chaining several counters into a wider one. The terminal-count flag is combinational. It is high when the next enabled count would wrap: the count is at the top value while counting up, or at zero while counting down. The active-low ripple output goes low only during the low half of the clock, and only while the flag is high and counting is enabled. A following stage can take this ripple output on its enable input when all stages share one clock, or on its clock input when all stages share one enable.

An active-low reset clears the count at once. Its release is synchronised to the clock.

Top module: `updown_cascade_counter`

## Requirements
- R1: Driving rst_n low clears count to 0 at once. After rst_n returns high, the count stays at 0 through the next two rising clock edges, whatever the other inputs are.
- R2: While cnt_en_n is high (1), the count holds its value across clock edges.
- R3: With cnt_en_n low (0), each rising edge adds one when dir_dn is 0 and subtracts one when dir_dn is 1.
- R4: A low level on preset_n copies preset_val onto count without waiting for a clock edge. While preset_n stays low, count equals preset_val at every rising edge, regardless of enable and direction.
- R5: When DECADE=0, counting up goes from 15 to 0 and counting down goes from 0 to 15. When DECADE=1, counting up goes from 9 to 0 and counting down goes from 0 to 9.
- R6: tc_flag is 1 exactly when count equals the top value (15 when DECADE=0, 9 when DECADE=1) with dir_dn=0, or when count equals 0 with dir_dn=1. It follows count and dir_dn without a clock delay.
- R7: ripple_n is 0 only while clk is low, tc_flag is 1 and cnt_en_n is 0. It is 1 during the whole high half of the clock and at every other time.
- R8: When DECADE=1, from an out-of-range count (10 to 15, which only a preset can reach) one enabled count up gives 0 and one enabled count down gives 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| preset_n | input | 1 | Active-low asynchronous preset |
| preset_val | input | WIDTH | Value loaded by the preset |
| count | output | WIDTH | Present count |
| tc_flag | output | 1 | Terminal-count (max/min) flag |
| ripple_n | output | 1 | Active-low cascade pulse, gated to the low clock phase |

## Verification
A binary instance and a decade instance run side by side on the same stimulus, and a behavioural model is compared with both twice per clock, once in each half of the clock. Long runs up and then down cover the shared counting path, and the two wrap points show where the two ranges differ. Enable-high stretches parked on a terminal value show whether hold and the enable gating of the ripple pulse work separately from the flag. Presets applied in the middle of the low phase separate the asynchronous load from an edge-triggered load. Out-of-range presets count in both directions, and the two instances must then take different paths.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  localparam int BCD_TOP = 9;

endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/cnt_step.sv
module cnt_step
  import cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  dir_e             dir_i,
  output logic [WIDTH-1:0] nxt_o
);

  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(BCD_TOP) : {WIDTH{1'b1}};

  generate
    if (DECADE) begin : g_decade
      always_comb begin
        if (dir_i == DIR_UP) begin
          nxt_o = (cnt_i >= TOP) ? '0 : cnt_i + 1'b1;
        end else if ((cnt_i == '0) || (cnt_i > TOP)) begin
          nxt_o = TOP;
        end else begin
          nxt_o = cnt_i - 1'b1;
        end
      end
    end else begin : g_binary
      always_comb begin
        if (dir_i == DIR_UP) begin
          nxt_o = cnt_i + 1'b1;
        end else begin
          nxt_o = cnt_i - 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cnt_term.sv
module cnt_term
  import cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  dir_e             dir_i,
  output logic             tc_o
);

  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(BCD_TOP) : {WIDTH{1'b1}};

  logic at_top;
  logic at_zero;

  always_comb begin
    at_top  = (cnt_i == TOP);
    at_zero = (cnt_i == '0);
    tc_o    = (dir_i == DIR_UP) ? at_top : at_zero;
  end

endmodule

// File: rtl/cnt_ripple.sv
module cnt_ripple (
  input  logic clk,
  input  logic tc_i,
  input  logic en_n_i,
  output logic ripple_n_o
);

  logic pulse;

  always_comb begin
    pulse      = tc_i & ~en_n_i & ~clk;
    ripple_n_o = ~pulse;
  end

endmodule

// File: rtl/updown_cascade_counter.sv
module updown_cascade_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_n,
  input  logic             dir_dn,
  input  logic             preset_n,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count,
  output logic             tc_flag,
  output logic             ripple_n
);

  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(BCD_TOP) : {WIDTH{1'b1}};

  logic             rst_q_n;
  dir_e             dir;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic [WIDTH-1:0] step;

  assign dir = dir_e'(dir_dn);

  cnt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_q_n(rst_q_n)
  );

  cnt_step #(.WIDTH(WIDTH), .DECADE(DECADE)) u_step (
    .cnt_i(cnt_q),
    .dir_i(dir),
    .nxt_o(step)
  );

  cnt_term #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
    .cnt_i(cnt_q),
    .dir_i(dir),
    .tc_o (tc_flag)
  );

  cnt_ripple u_ripple (
    .clk       (clk),
    .tc_i      (tc_flag),
    .en_n_i    (cnt_en_n),
    .ripple_n_o(ripple_n)
  );

  always_comb begin
    cnt_d = cnt_en_n ? cnt_q : step;
  end

  always_ff @(posedge clk or negedge rst_q_n or negedge preset_n) begin
    if (!rst_q_n) begin
      cnt_q <= '0;
    end else if (!preset_n) begin
      cnt_q <= preset_val;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (preset_n && cnt_en_n) |=> (!preset_n || $stable(count)));

  p_inc_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (preset_n && !cnt_en_n && !dir_dn && (count < TOP))
      |=> (!preset_n || (count == $past(count) + 1'b1)));

  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (preset_n && !cnt_en_n && dir_dn && (count != '0) && (count <= TOP))
      |=> (!preset_n || (count == $past(count) - 1'b1)));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !preset_n |-> (count == preset_val));

  p_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (preset_n && !cnt_en_n && tc_flag && !dir_dn) |=> (!preset_n || (count == '0)));

  p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (preset_n && !cnt_en_n && tc_flag && dir_dn) |=> (!preset_n || (count == TOP)));

  p_tc_ends_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    tc_flag |-> ((count == '0) || (count == TOP)));

  p_rco_low_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tc_flag && !cnt_en_n) |-> !ripple_n);

  p_rco_idle_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !tc_flag |-> ripple_n);

  generate
    if (DECADE) begin : g_bcd_chk
      p_recover_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
        (preset_n && !cnt_en_n && (count > TOP))
          |=> (!preset_n || (count == ($past(dir_dn) ? TOP : '0))));
    end
  endgenerate

endmodule

// File: tb/sim_updown_cascade_counter.sv
`timescale 1ns/1ps
module sim_updown_cascade_counter;

  logic       clk;
  logic       rst_n;
  logic       en_n;
  logic       dn;
  logic       load_n;
  logic [3:0] data;
  logic [3:0] cnt_b, cnt_d;
  logic       tc_b, tc_d;
  logic       rco_b, rco_d;

  int total = 0;
  int fails = 0;
  bit done = 0;

  int mb, md, rel;

  updown_cascade_counter #(.WIDTH(4), .DECADE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(en_n), .dir_dn(dn), .preset_n(load_n),
    .preset_val(data), .count(cnt_b), .tc_flag(tc_b), .ripple_n(rco_b));

  updown_cascade_counter #(.WIDTH(4), .DECADE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(en_n), .dir_dn(dn), .preset_n(load_n),
    .preset_val(data), .count(cnt_d), .tc_flag(tc_d), .ripple_n(rco_d));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference for both ranges
  always @(posedge clk or negedge rst_n or negedge load_n) begin
    if (!rst_n) begin
      mb = 0; md = 0; rel = 0;
    end else if (rel < 2) begin
      rel = rel + 1;
    end else if (!load_n) begin
      mb = data; md = data;
    end else if (!en_n) begin
      if (!dn) begin
        mb = (mb + 1) % 16;
        md = (md >= 9) ? 0 : md + 1;
      end else begin
        mb = (mb + 15) % 16;
        md = (md == 0 || md > 9) ? 9 : md - 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag, input bit high_phase);
    int tb_e, td_e;
    tb_e = dn ? (mb == 0) : (mb == 15);
    td_e = dn ? (md == 0) : (md == 9);
    chk(tag, "bin count", cnt_b, mb);
    chk(tag, "dec count", cnt_d, md);
    chk(tag, "bin tc", tc_b, tb_e);
    chk(tag, "dec tc", tc_d, td_e);
    if (high_phase) begin
      chk(tag, "bin ripple hi", rco_b, 1);
      chk(tag, "dec ripple hi", rco_d, 1);
    end else begin
      chk(tag, "bin ripple lo", rco_b, (tb_e && !en_n) ? 0 : 1);
      chk(tag, "dec ripple lo", rco_d, (td_e && !en_n) ? 0 : 1);
    end
  endtask

  task automatic tick(input logic e, input logic d, input string tag);
    @(posedge clk);
    #1; en_n = e; dn = d;
    #3; compare(tag, 1'b1);
    #4; compare(tag, 1'b0);
  endtask

  task automatic preset(input logic [3:0] v, input string tag);
    @(posedge clk);
    #1; data = v;
    #5; load_n = 1'b0;
    #2; chk(tag, "bin preset now", cnt_b, v);
    chk(tag, "dec preset now", cnt_d, v);
    @(posedge clk);
    #1; load_n = 1'b1;
    #3; compare(tag, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; en_n = 1'b1; dn = 1'b0; load_n = 1'b1; data = 4'd0;
    #23;
    chk("R1", "bin count in reset", cnt_b, 0);
    chk("R1", "dec count in reset", cnt_d, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    tick(1'b0, 1'b0, "R1");
    tick(1'b0, 1'b0, "R1");
    // counting up through both wrap points
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b0, "R3");
    for (int i = 0; i < 12; i++) tick(1'b0, 1'b0, "R5");
    // hold
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, "R2");
    // counting down through both wrap points
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b1, "R3");
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b1, "R5");
    // terminal flag parked at top and zero, both directions, enable off
    preset(4'd9, "R6");
    tick(1'b1, 1'b0, "R6");
    tick(1'b1, 1'b1, "R6");
    preset(4'd15, "R6");
    tick(1'b1, 1'b0, "R6");
    preset(4'd0, "R6");
    tick(1'b1, 1'b1, "R6");
    tick(1'b1, 1'b0, "R6");
    // ripple pulse with and without enable
    preset(4'd9, "R7");
    tick(1'b0, 1'b0, "R7");
    preset(4'd15, "R7");
    tick(1'b1, 1'b0, "R7");
    tick(1'b0, 1'b0, "R7");
    tick(1'b0, 1'b1, "R7");
    tick(1'b0, 1'b1, "R7");
    // mid-cycle presets then counting
    preset(4'd5, "R4");
    tick(1'b0, 1'b0, "R4");
    preset(4'd0, "R4");
    tick(1'b0, 1'b1, "R4");
    preset(4'd11, "R4");
    // out-of-range recovery in decade range
    preset(4'd12, "R8");
    tick(1'b0, 1'b0, "R8");
    tick(1'b0, 1'b0, "R8");
    preset(4'd14, "R8");
    tick(1'b0, 1'b1, "R8");
    tick(1'b0, 1'b1, "R8");
    preset(4'd10, "R8");
    tick(1'b0, 1'b0, "R8");
    tick(1'b1, 1'b0, "R8");
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule